// File: doc/BRIEF.md
# Set-Associative Cache Cycle-Cost Model

This block models the timing of a set-associative data cache without storing any data. It keeps only valid bits, tags, dirty bits and replacement state. Each request names one block-aligned byte address and says whether it is a load or a store. The block decides whether the access hits, misses or displaces a resident block. It then returns the exact number of simulated cycles the access would take, given the configured cache access time and main-memory latency. Saturating counters keep a running total of hits, misses and evictions.

The geometry is fixed by parameters: number of sets, number of ways and block size. Four settings are plain control pins sampled when a request is accepted: replacement policy, write policy, cache latency and memory latency. Main memory transfers a block as 8-byte beats. The first beat costs the memory latency and every further beat adds one cycle, so one block transfer costs `mem_lat + BLOCK_BYTES/8 - 1`.

Requests and responses each use a valid/ready handshake, and at most one response is held. A request is accepted only when the response slot is empty or is being drained in the same cycle. While `rsp_ready` is low, a held response does not change and no new request is taken.

Top module: `cache_cost_model`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is high exactly when no response is held or `rsp_ready` is high. The response is presented one cycle after acceptance. It stays unchanged, with `req_ready` low, while `rsp_ready` is low.
- R2: Byte address bits [log2(BLOCK_BYTES)-1:0] are ignored. The next log2(NUM_SETS) bits select the set, and all remaining upper bits form the tag, so any two addresses inside one block share a single entry.
- R3: Every response has exactly one of `rsp_hit`/`rsp_miss` set. A load hit costs `cfg_cache_lat` cycles.
- R4: A load miss costs `cfg_mem_lat + BLOCK_BYTES/8 - 1 + cfg_cache_lat`, and the filled block is clean.
- R5: With `cfg_write_back`=0, a store hit costs `cfg_cache_lat + cfg_mem_lat`. A store miss first fetches and fills, so it costs `(cfg_mem_lat + BLOCK_BYTES/8 - 1 + cfg_cache_lat) + (cfg_cache_lat + cfg_mem_lat)`. No block is marked dirty.
- R6: With `cfg_write_back`=1, a store hit costs `cfg_cache_lat` and a store miss costs `cfg_mem_lat + BLOCK_BYTES/8 - 1 + 2*cfg_cache_lat`. Either way the block becomes dirty.
- R7: A miss into a set whose ways are all valid raises `rsp_evict` (never on a hit). A clean victim adds no cycles.
- R8: A dirty victim adds one block write-back, `cfg_mem_lat + BLOCK_BYTES/8 - 1` cycles, to the miss cost.
- R9: With `cfg_lru`=1, the victim in a full set is the way whose most recent load or store is older than that of every other way in the set (exact LRU).
- R10: Under either policy, a miss fills the lowest-numbered invalid way before any valid way is replaced. With `cfg_lru`=0, the victim in a full set comes from a free-running LFSR seeded by `LFSR_SEED`.
- R11: `hit_count`, `miss_count` and `evict_count` each rise by one per accepted access of their kind, and each holds at all-ones instead of wrapping.
- R12: After reset, all ways are invalid and clean, the counters read zero, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lru | input | 1 | Replacement: 1 = exact LRU, 0 = pseudo-random |
| cfg_write_back | input | 1 | Write policy: 1 = write-back, 0 = write-through |
| cfg_cache_lat | input | LAT_W | Cache access time in cycles |
| cfg_mem_lat | input | LAT_W | Cost of the first 8-byte memory beat |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Access hit |
| rsp_miss | output | 1 | Access missed |
| rsp_evict | output | 1 | A valid block was replaced |
| rsp_cycles | output | CYC_W | Cycle cost of the access |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |
| evict_count | output | CNT_W | Saturating eviction total |

## Verification
The bench drives one set through a chain of hits and misses in which each LRU choice is proved by a later probe. If the model evicted the wrong way, a block expected to hit would miss, and a block expected to miss would hit. A second set in write-back mode checks the dirty bits. It stores into a block, replaces it, reloads it through a load, and replaces it again. A model that added the write-back on clean victims, or lost the dirty bit, would report costs off by one block transfer. Random mode is checked by filling every way and probing them all as hits, which catches a design that lets the LFSR overwrite a valid way while an invalid way is still free. A stalled response, with a second request waiting behind it, shows whether the model holds the first result and accepts the queued request on the same edge as the drain.

// File: rtl/cache_cm_pkg.sv
package cache_cm_pkg;

  typedef enum logic {
    VICT_RANDOM = 1'b0,
    VICT_LRU    = 1'b1
  } victim_pol_e;

  typedef enum logic {
    WPOL_THROUGH = 1'b0,
    WPOL_BACK    = 1'b1
  } write_pol_e;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cache_cm_tags.sv
module cache_cm_tags #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 25,
  parameter int IDX_W    = 3,
  parameter int WAY_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic                hit_o,
  output logic [WAY_W-1:0]    hit_way_o,
  output logic [NUM_WAYS-1:0] valid_o,
  output logic [NUM_WAYS-1:0] dirty_o,
  input  logic                upd_en,
  input  logic [WAY_W-1:0]    upd_way,
  input  logic                upd_fill,
  input  logic                upd_dirty
);

  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] dirty_q [NUM_SETS];
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] match;

  assign valid_o = valid_q[lk_idx];
  assign dirty_o = dirty_q[lk_idx];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (upd_en) begin
      if (upd_fill) valid_q[lk_idx][upd_way] <= 1'b1;
      dirty_q[lk_idx][upd_way] <= upd_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_fill) tag_q[lk_idx][upd_way] <= lk_tag;
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R5
  dirty_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_o & ~valid_o) == '0);

endmodule

// File: rtl/cache_cm_victim.sv
module cache_cm_victim #(
  parameter int          NUM_SETS  = 8,
  parameter int          NUM_WAYS  = 4,
  parameter int          IDX_W     = 3,
  parameter int          WAY_W     = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    idx,
  input  logic                use_lru,
  input  logic [NUM_WAYS-1:0] valid_vec,
  input  logic                touch_en,
  input  logic [WAY_W-1:0]    touch_way,
  output logic [WAY_W-1:0]    victim_o
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);
  localparam logic [15:0]      TAPS   = 16'hB400;

  logic [WAY_W-1:0]    age_q [NUM_SETS][NUM_WAYS];
  logic [15:0]         lfsr_q;
  logic [NUM_WAYS-1:0] oldest_vec;
  logic                any_free;
  logic [WAY_W-1:0]    free_way, old_way, rnd_way;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= (LFSR_SEED == 16'h0) ? 16'h1 : LFSR_SEED;
    else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[idx][w] <= '0;
        else if (age_q[idx][w] < age_q[idx][touch_way])
          age_q[idx][w] <= age_q[idx][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_old
    assign oldest_vec[w] = (age_q[idx][w] == OLDEST);
  end

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    old_way  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (oldest_vec[w]) old_way = WAY_W'(w);
    end
  end

  assign rnd_way  = WAY_W'(lfsr_q % 16'(NUM_WAYS));
  assign victim_o = any_free ? free_way : (use_lru ? old_way : rnd_way);

  // R9
  lru_one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // R10
  lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0);

endmodule

// File: rtl/cache_cm_cost.sv
module cache_cm_cost #(
  parameter int LAT_W = 12,
  parameter int CYC_W = 16,
  parameter int BEATS = 2
) (
  input  logic             is_store,
  input  logic             hit,
  input  logic             write_back,
  input  logic             victim_dirty,
  input  logic [LAT_W-1:0] cache_lat,
  input  logic [LAT_W-1:0] mem_lat,
  output logic [CYC_W-1:0] cycles
);

  logic [CYC_W-1:0] c_lat, m_lat, burst, fill, flush, access;

  always_comb begin
    c_lat  = CYC_W'(cache_lat);
    m_lat  = CYC_W'(mem_lat);
    burst  = m_lat + CYC_W'(BEATS - 1);
    fill   = hit ? '0 : (burst + c_lat);
    flush  = (!hit && victim_dirty) ? burst : '0;
    if (!is_store)       access = hit ? c_lat : '0;
    else if (write_back) access = c_lat;
    else                 access = c_lat + m_lat;
    cycles = flush + fill + access;
  end

endmodule

// File: rtl/cache_cm_satcnt.sv
module cache_cm_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1) |=> (count == '1));

  // R11
  sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (count != '1)) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/cache_cost_model.sv
module cache_cost_model
  import cache_cm_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          NUM_SETS    = 8,
  parameter int          NUM_WAYS    = 4,
  parameter int          BLOCK_BYTES = 16,
  parameter int          LAT_W       = 12,
  parameter int          CYC_W       = 16,
  parameter int          CNT_W       = 16,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lru,
  input  logic              cfg_write_back,
  input  logic [LAT_W-1:0]  cfg_cache_lat,
  input  logic [LAT_W-1:0]  cfg_mem_lat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_evict,
  output logic [CYC_W-1:0]  rsp_cycles,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);

  localparam int BEATS    = BLOCK_BYTES / 8;
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int LOG_SETS = $clog2(NUM_SETS);
  localparam int IDX_W    = width_of(NUM_SETS);
  localparam int WAY_W    = width_of(NUM_WAYS);
  localparam int TAG_W    = ADDR_W - OFF_W - LOG_SETS;

  victim_pol_e         vpol;
  write_pol_e          wpol;
  logic                accept;
  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic                hit;
  logic [WAY_W-1:0]    hit_way, victim_way, sel_way;
  logic [NUM_WAYS-1:0] valid_vec, dirty_vec;
  logic                evict, victim_dirty, is_wb_store, new_dirty;
  logic [CYC_W-1:0]    cost;

  assign vpol   = victim_pol_e'(cfg_lru);
  assign wpol   = write_pol_e'(cfg_write_back);
  assign accept = req_valid && req_ready;
  assign lk_idx = IDX_W'((req_addr >> OFF_W) & ADDR_W'(NUM_SETS - 1));
  assign lk_tag = TAG_W'(req_addr >> (OFF_W + LOG_SETS));

  cache_cm_tags #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .valid_o   (valid_vec),
    .dirty_o   (dirty_vec),
    .upd_en    (accept),
    .upd_way   (sel_way),
    .upd_fill  (!hit),
    .upd_dirty (new_dirty)
  );

  cache_cm_victim #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W),
    .WAY_W(WAY_W), .LFSR_SEED(LFSR_SEED)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (lk_idx),
    .use_lru   (vpol == VICT_LRU),
    .valid_vec (valid_vec),
    .touch_en  (accept),
    .touch_way (sel_way),
    .victim_o  (victim_way)
  );

  assign sel_way      = hit ? hit_way : victim_way;
  assign evict        = !hit && valid_vec[victim_way];
  assign victim_dirty = evict && dirty_vec[victim_way];
  assign is_wb_store  = req_store && (wpol == WPOL_BACK);
  assign new_dirty    = is_wb_store || (hit && dirty_vec[hit_way]);

  cache_cm_cost #(.LAT_W(LAT_W), .CYC_W(CYC_W), .BEATS(BEATS)) u_cost (
    .is_store     (req_store),
    .hit          (hit),
    .write_back   (wpol == WPOL_BACK),
    .victim_dirty (victim_dirty),
    .cache_lat    (cfg_cache_lat),
    .mem_lat      (cfg_mem_lat),
    .cycles       (cost)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_evict  <= 1'b0;
      rsp_cycles <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= hit;
      rsp_miss   <= !hit;
      rsp_evict  <= evict;
      rsp_cycles <= cost;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  cache_cm_satcnt #(.W(CNT_W)) u_hits (
    .clk(clk), .rst_n(rst_n), .inc(accept && hit), .count(hit_count));
  cache_cm_satcnt #(.W(CNT_W)) u_misses (
    .clk(clk), .rst_n(rst_n), .inc(accept && !hit), .count(miss_count));
  cache_cm_satcnt #(.W(CNT_W)) u_evicts (
    .clk(clk), .rst_n(rst_n), .inc(accept && evict), .count(evict_count));

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cycles)
                                   && $stable(rsp_hit) && $stable(rsp_evict)));

  // R1
  no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R3
  hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));

  // R7
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict) |-> rsp_miss);

endmodule

// File: tb/cache_cost_model_tb.sv
`timescale 1ns/1ps
module cache_cost_model_tb;

  localparam int N_STEPS = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_lru = 1'b1, cfg_write_back = 1'b0;
  logic [11:0] cfg_cache_lat = 12'd13, cfg_mem_lat = 12'd230;
  logic        req_valid = 1'b0, req_store = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_evict;
  logic [15:0] rsp_cycles;
  logic [3:0]  hit_count, miss_count, evict_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cache_cost_model #(
    .ADDR_W(32), .NUM_SETS(8), .NUM_WAYS(4), .BLOCK_BYTES(16),
    .LAT_W(12), .CYC_W(16), .CNT_W(4), .LFSR_SEED(16'hACE1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lru(cfg_lru), .cfg_write_back(cfg_write_back),
    .cfg_cache_lat(cfg_cache_lat), .cfg_mem_lat(cfg_mem_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_evict(rsp_evict),
    .rsp_cycles(rsp_cycles), .hit_count(hit_count), .miss_count(miss_count),
    .evict_count(evict_count)
  );

  // layout: store, wb, lru, tag[7:0], set[2:0], off[3:0], hit, evict, cycles[15:0]
  function automatic logic [35:0] mk(input logic st, input logic wb, input logic lru,
                                     input logic [7:0] tag, input logic [2:0] set,
                                     input logic [3:0] off, input logic hit,
                                     input logic ev, input logic [15:0] cyc);
    return {st, wb, lru, tag, set, off, hit, ev, cyc};
  endfunction

  // cache 13, memory 230, 16-byte blocks: burst = 231
  localparam logic [35:0] STEPS [N_STEPS] = '{
    mk(0,0,1, 1,1,0, 0,0, 244),  // R4 load miss
    mk(0,0,1, 1,1,8, 1,0,  13),  // R2 other offset, R3 hit
    mk(1,0,1, 1,1,0, 1,0, 243),  // R5 WT store hit
    mk(1,0,1, 2,1,0, 0,0, 487),  // R5 WT store miss
    mk(0,0,1, 3,1,0, 0,0, 244),
    mk(0,0,1, 4,1,0, 0,0, 244),
    mk(0,0,1, 1,1,0, 1,0,  13),
    mk(0,0,1, 5,1,0, 0,1, 244),  // R9 evicts tag 2, R7 clean victim
    mk(0,0,1, 2,1,0, 0,1, 244),  // R9 proves tag 2 left
    mk(0,0,1, 1,1,0, 1,0,  13),
    mk(0,0,1, 4,1,0, 1,0,  13),
    mk(0,0,1, 3,1,0, 0,1, 244),  // R9
    mk(0,0,1, 5,1,0, 0,1, 244),  // R9
    mk(1,1,1, 1,2,0, 0,0, 257),  // R6 WB store miss
    mk(1,1,1, 1,2,0, 1,0,  13),  // R6 WB store hit
    mk(0,1,1, 2,2,0, 0,0, 244),
    mk(0,1,1, 3,2,0, 0,0, 244),
    mk(0,1,1, 4,2,0, 0,0, 244),
    mk(0,1,1, 5,2,0, 0,1, 475),  // R8 dirty victim
    mk(0,1,1, 2,2,0, 1,0,  13),
    mk(1,1,1, 6,2,0, 0,1, 257),  // R7 clean victim under WB
    mk(0,1,1, 1,2,0, 0,1, 244),  // R4 reload is clean
    mk(0,1,1, 7,2,0, 0,1, 244),
    mk(0,1,1, 8,2,0, 0,1, 244),
    mk(0,1,1, 9,2,0, 0,1, 475),  // R8 dirty store-miss block
    mk(0,0,0, 1,3,0, 0,0, 244),  // R10 random mode fill
    mk(0,0,0, 2,3,0, 0,0, 244),
    mk(0,0,0, 3,3,0, 0,0, 244),
    mk(0,0,0, 4,3,0, 0,0, 244),
    mk(0,0,0, 1,3,0, 1,0,  13),  // R10 all four kept
    mk(0,0,0, 2,3,0, 1,0,  13),
    mk(0,0,0, 3,3,0, 1,0,  13),
    mk(0,0,0, 4,3,0, 1,0,  13),
    mk(0,0,0, 5,3,0, 0,1, 244),  // R10 replaces a valid way
    mk(0,0,0, 5,3,0, 1,0,  13)
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input logic [7:0] tag, input logic [2:0] set,
                                          input logic [3:0] off);
    return {17'd0, tag, set, off};
  endfunction

  task automatic issue(input logic st, input logic wb, input logic lru,
                       input logic [31:0] addr);
    @(negedge clk);
    cfg_write_back = wb; cfg_lru = lru;
    req_valid = 1'b1; req_store = st; req_addr = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12", "rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "req_ready after reset", 32'(req_ready), 1);
    chk("R12", "hit_count after reset", 32'(hit_count), 0);
    chk("R12", "miss_count after reset", 32'(miss_count), 0);

    for (int i = 0; i < N_STEPS; i++) begin
      logic [35:0] e;
      string rq;
      e = STEPS[i];
      issue(e[35], e[34], e[33], addr_of(e[32:25], e[24:22], e[21:18]));
      if (e[35]) rq = e[34] ? "R6" : "R5";
      else       rq = e[17] ? "R3" : "R4";
      if (e[16]) rq = e[34] ? "R8" : "R9";
      if (e[33] == 1'b0) rq = "R10";
      chk("R1", $sformatf("step %0d rsp_valid", i), 32'(rsp_valid), 1);
      chk(rq, $sformatf("step %0d hit", i), 32'(rsp_hit), 32'(e[17]));
      chk("R7", $sformatf("step %0d evict", i), 32'(rsp_evict), 32'(e[16]));
      chk(rq, $sformatf("step %0d cycles", i), 32'(rsp_cycles), 32'(e[15:0]));
    end

    // R11 counters: 12 hits, 23 misses (saturated at 15), 11 evictions
    @(negedge clk);
    chk("R11", "hit_count", 32'(hit_count), 12);
    chk("R11", "miss_count saturated", 32'(miss_count), 15);
    chk("R11", "evict_count", 32'(evict_count), 11);
    for (int k = 0; k < 4; k++) issue(1'b0, 1'b0, 1'b0, addr_of(8'd5, 3'd3, 4'd0));
    @(negedge clk);
    chk("R11", "hit_count saturated", 32'(hit_count), 15);

    // R1 back-pressure: first response held, queued request waits
    rsp_ready = 1'b0;
    issue(1'b0, 1'b0, 1'b1, addr_of(8'd1, 3'd4, 4'd0));
    req_valid = 1'b1; req_store = 1'b0; req_addr = addr_of(8'd1, 3'd4, 4'd4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", "req_ready while stalled", 32'(req_ready), 0);
      chk("R1", "held cycles while stalled", 32'(rsp_cycles), 244);
      chk("R1", "held miss while stalled", 32'(rsp_miss), 1);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "queued request response valid", 32'(rsp_valid), 1);
    chk("R1", "queued request hit", 32'(rsp_hit), 1);
    chk("R1", "queued request cycles", 32'(rsp_cycles), 13);
    @(negedge clk);
    chk("R1", "drained rsp_valid", 32'(rsp_valid), 0);

    // R12 second reset clears valid bits and counters
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12", "evict_count after reset", 32'(evict_count), 0);
    issue(1'b0, 1'b0, 1'b1, addr_of(8'd1, 3'd1, 4'd0));
    chk("R12", "miss after reset", 32'(rsp_miss), 1);
    chk("R12", "cost after reset", 32'(rsp_cycles), 244);

    finish_run();
  end

endmodule